// File: doc/BRIEF.md
# Boot Reset Sequencer with ROM Width Strap

This block governs how a processor core enters and leaves reset and supplies the first instruction words from the boot ROM. While the external active-low reset is low, the block holds the core stopped, drives its own reset output low, and issues no ROM traffic. The reset input is released into the clock domain through a two-flop synchronizer. After release, the block runs a fixed exit sequence. It writes the core's current program counter into the supervisor link register and then the current status word into the saved-status register. It then forces supervisor mode with both interrupt classes masked. Next it waits out a fixed clock-lock interval. Only after that does it fetch `BOOT_WORDS` instruction words, starting at address zero.

A width strap is captured on every clock edge while the synchronized reset is low, and it is frozen afterwards. When the strap is high, each instruction word comes from one 32-bit ROM read. When it is low, the block makes two halfword reads and joins them into one word. The lower address goes to bits [15:0] and the next address goes to bits [31:16]. After the sequence, the system control outputs leave address translation, both caches, the write buffer and alignment checking disabled, and select little-endian operation.

The ROM request, ROM response and instruction output are valid/ready streams. A request, once valid, keeps its address and size until ready is seen, and only one request is outstanding at a time. The ROM response is accepted only while `rom_rsp_ready` is high. A valid instruction word keeps its data and address until `instr_ready` is high. No new ROM request is made while a word is waiting.

Top module: `boot_reset_seq`

## Requirements
- R1: While `rst_n_in` is low, and until the exit sequence starts (the third clock edge after `rst_n_in` rises), `rst_out_n` is 0, `core_hold` is 1, `rom_req_valid` is 0 and no save or force strobe is high.
- R2: Sampling between edges, `save_link_we` is high with `save_data` equal to `cur_pc` for the cycle after the third edge following release. In the next cycle, `save_stat_we` is high with `save_data` equal to `cur_status`.
- R3: In the cycle after the status write, `force_we` is high. From then on, `core_mode` is 5'b10011 and `core_irq_mask` and `core_fiq_mask` are both 1.
- R4: After the exit sequence, all six bits of `sys_ctl` are 0. The bits are [0] translation enable, [1] instruction cache, [2] data cache, [3] write buffer, [4] alignment check and [5] big-endian, so 0 in bit 5 means little-endian.
- R5: `strap_wide` is captured on every edge at which the synchronized reset is low, and it is shown on `rom_wide`. Changes to the strap after the second edge following release have no effect on `rom_wide` or on ROM access size.
- R6: With `rom_wide`=1, each word takes one request of `rom_req_size`=1 at address 4*i. The full 32-bit response becomes the word.
- R7: With `rom_wide`=0, each word takes two requests of `rom_req_size`=0, at addresses 4*i and 4*i+2. Response bits [15:0] of the first request fill word bits [15:0], and those of the second request fill bits [31:16]. Response bits [31:16] are ignored.
- R8: `clk_ready` rises `LOCK_CYCLES`+1 cycles after the `force_we` cycle and then stays high. No ROM request is made before it rises.
- R9: The first ROM request is at address 0 and the words are presented in order with `instr_addr`=4*i. After `BOOT_WORDS` words are accepted, `boot_done` rises, `core_hold` falls, and no further request is made.
- R10: Back-pressure: `rom_req_valid` and `rom_req_addr` hold until `rom_req_ready`, and `instr_valid` and `instr_data` hold until `instr_ready`.
- R11: Driving `rst_n_in` low at any time clears `rst_out_n`, `rom_req_valid` and `clk_ready` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_in | input | 1 | Asynchronous active-low reset request |
| strap_wide | input | 1 | ROM width strap: 1 = 32-bit, 0 = 16-bit |
| rst_out_n | output | 1 | Active-low reset to the rest of the system |
| core_hold | output | 1 | Core must not execute while high |
| cur_pc | input | 32 | Core's current program counter |
| cur_status | input | 32 | Core's current status word |
| save_link_we | output | 1 | Write strobe for the supervisor link register |
| save_stat_we | output | 1 | Write strobe for the supervisor saved status |
| save_data | output | 32 | Data for the active save strobe |
| force_we | output | 1 | Strobe applying forced mode and masks |
| core_mode | output | 5 | Forced mode field |
| core_irq_mask | output | 1 | Normal interrupt disable |
| core_fiq_mask | output | 1 | Fast interrupt disable |
| sys_ctl | output | 6 | Post-reset system control bits |
| clk_ready | output | 1 | Clock lock interval has elapsed |
| rom_wide | output | 1 | Latched ROM width |
| rom_req_valid | output | 1 | ROM request valid |
| rom_req_ready | input | 1 | ROM request ready |
| rom_req_addr | output | 32 | ROM byte address |
| rom_req_size | output | 1 | 1 = word, 0 = halfword |
| rom_rsp_valid | input | 1 | ROM response valid |
| rom_rsp_ready | output | 1 | ROM response ready |
| rom_rsp_data | input | 32 | ROM response data |
| instr_valid | output | 1 | Instruction word valid |
| instr_ready | input | 1 | Instruction word ready |
| instr_data | output | 32 | Assembled instruction word |
| instr_addr | output | 32 | Byte address of the word |
| boot_done | output | 1 | All boot words delivered |

## Verification
Two pairs of events can fall in the same cycle. The first is a strap change against the edge at which the synchronizer releases. The bench flips the strap right after the last sampling edge, then judges it by the address and size pattern of every later ROM request. The second is a reset re-entry against a halfword assembly in progress. The bench pulls the reset low between edges while a request or response is in flight, and expects reset out, request valid and clock ready to drop at once. It then expects a fresh boot to restart cleanly from address zero. Both ROM streams and the instruction stream are stalled on fixed rotating patterns, so handshakes meet stalls in every phase, and every word is compared with a value computed from its address.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    SQ_RESET,
    SQ_SAVE_LINK,
    SQ_SAVE_STAT,
    SQ_FORCE,
    SQ_LOCK,
    SQ_BOOT,
    SQ_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    AS_IDLE,
    AS_REQ,
    AS_WAIT,
    AS_OUT
  } asm_state_e;

  localparam logic [4:0] MODE_SUPV = 5'b10011;
  localparam int         CTL_BITS  = 6;

endpackage

// File: rtl/boot_rst_sync.sv
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain[STAGES-1];

  assert_sync_drops_R11: assert property (@(posedge clk) !arst_n |-> !rst_n);

endmodule

// File: rtl/boot_lock_timer.sv
module boot_lock_timer #(
  parameter int LOCK_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expire,
  output logic locked
);

  localparam int CW = $clog2(LOCK_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          busy;

  assign expire = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      busy   <= 1'b0;
      locked <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CW'(LOCK_CYCLES - 1);
    end else if (expire) begin
      busy   <= 1'b0;
      locked <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_locked_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  assert_lock_after_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(busy));

endmodule

// File: rtl/boot_word_asm.sv
module boot_word_asm
  import boot_pkg::*;
#(
  parameter int BOOT_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        wide,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [31:0] req_addr,
  output logic        req_size,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_data,
  output logic        instr_valid,
  input  logic        instr_ready,
  output logic [31:0] instr_data,
  output logic [31:0] instr_addr,
  output logic        done
);

  localparam int WIW = $clog2(BOOT_WORDS + 1);

  asm_state_e     st;
  logic [WIW-1:0] widx;
  logic           hidx;
  logic [31:0]    buffer;
  logic [31:0]    word_base;

  assign word_base   = 32'(widx) << 2;
  assign req_valid   = (st == AS_REQ);
  assign rsp_ready   = (st == AS_WAIT);
  assign instr_valid = (st == AS_OUT);
  assign req_size    = wide;
  assign req_addr    = word_base | {30'b0, (!wide && hidx), 1'b0};
  assign instr_data  = buffer;
  assign instr_addr  = word_base;
  assign done        = (st == AS_IDLE) && (widx == WIW'(BOOT_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= AS_IDLE;
      widx   <= '0;
      hidx   <= 1'b0;
      buffer <= '0;
    end else begin
      unique case (st)
        AS_IDLE: if (go && (widx != WIW'(BOOT_WORDS))) st <= AS_REQ;
        AS_REQ:  if (req_ready) st <= AS_WAIT;
        AS_WAIT: if (rsp_valid) begin
          if (wide) begin
            buffer <= rsp_data;
            st     <= AS_OUT;
          end else if (!hidx) begin
            buffer[15:0] <= rsp_data[15:0];
            hidx         <= 1'b1;
            st           <= AS_REQ;
          end else begin
            buffer[31:16] <= rsp_data[15:0];
            hidx          <= 1'b0;
            st            <= AS_OUT;
          end
        end
        AS_OUT: if (instr_ready) begin
          widx <= widx + 1'b1;
          st   <= (widx == WIW'(BOOT_WORDS - 1)) ? AS_IDLE : AS_REQ;
        end
        default: st <= AS_IDLE;
      endcase
    end
  end

  assert_req_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));
  assert_word_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && !instr_ready |=> instr_valid && $stable(instr_data));
  assert_wide_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && wide |-> req_addr[1:0] == 2'b00);
  assert_half_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !wide |-> req_addr[0] == 1'b0);

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import boot_pkg::*;
#(
  parameter int LOCK_CYCLES = 64,
  parameter int BOOT_WORDS  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n_in,
  input  logic                strap_wide,
  output logic                rst_out_n,
  output logic                core_hold,
  input  logic [31:0]         cur_pc,
  input  logic [31:0]         cur_status,
  output logic                save_link_we,
  output logic                save_stat_we,
  output logic [31:0]         save_data,
  output logic                force_we,
  output logic [4:0]          core_mode,
  output logic                core_irq_mask,
  output logic                core_fiq_mask,
  output logic [CTL_BITS-1:0] sys_ctl,
  output logic                clk_ready,
  output logic                rom_wide,
  output logic                rom_req_valid,
  input  logic                rom_req_ready,
  output logic [31:0]         rom_req_addr,
  output logic                rom_req_size,
  input  logic                rom_rsp_valid,
  output logic                rom_rsp_ready,
  input  logic [31:0]         rom_rsp_data,
  output logic                instr_valid,
  input  logic                instr_ready,
  output logic [31:0]         instr_data,
  output logic [31:0]         instr_addr,
  output logic                boot_done
);

  logic       rst_sync;
  seq_state_e state;
  logic       strap_q;
  logic       lock_expire;
  logic       asm_done;

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (rst_n_in),
    .rst_n  (rst_sync)
  );

  always_ff @(posedge clk) begin
    if (!rst_sync) strap_q <= strap_wide;
  end
  assign rom_wide = strap_q;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) state <= SQ_RESET;
    else begin
      unique case (state)
        SQ_RESET:     state <= SQ_SAVE_LINK;
        SQ_SAVE_LINK: state <= SQ_SAVE_STAT;
        SQ_SAVE_STAT: state <= SQ_FORCE;
        SQ_FORCE:     state <= SQ_LOCK;
        SQ_LOCK:      if (lock_expire) state <= SQ_BOOT;
        SQ_BOOT:      if (asm_done) state <= SQ_DONE;
        default:      state <= SQ_DONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      core_mode     <= '0;
      core_irq_mask <= 1'b0;
      core_fiq_mask <= 1'b0;
      sys_ctl       <= '0;
    end else if (state == SQ_FORCE) begin
      core_mode     <= MODE_SUPV;
      core_irq_mask <= 1'b1;
      core_fiq_mask <= 1'b1;
      sys_ctl       <= '0;
    end
  end

  assign rst_out_n    = (state != SQ_RESET);
  assign core_hold    = (state != SQ_DONE);
  assign boot_done    = (state == SQ_DONE);
  assign save_link_we = (state == SQ_SAVE_LINK);
  assign save_stat_we = (state == SQ_SAVE_STAT);
  assign force_we     = (state == SQ_FORCE);
  assign save_data    = (state == SQ_SAVE_STAT) ? cur_status : cur_pc;

  boot_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk    (clk),
    .rst_n  (rst_sync),
    .start  (state == SQ_FORCE),
    .expire (lock_expire),
    .locked (clk_ready)
  );

  boot_word_asm #(.BOOT_WORDS(BOOT_WORDS)) u_asm (
    .clk         (clk),
    .rst_n       (rst_sync),
    .go          (state == SQ_BOOT),
    .wide        (strap_q),
    .req_valid   (rom_req_valid),
    .req_ready   (rom_req_ready),
    .req_addr    (rom_req_addr),
    .req_size    (rom_req_size),
    .rsp_valid   (rom_rsp_valid),
    .rsp_ready   (rom_rsp_ready),
    .rsp_data    (rom_rsp_data),
    .instr_valid (instr_valid),
    .instr_ready (instr_ready),
    .instr_data  (instr_data),
    .instr_addr  (instr_addr),
    .done        (asm_done)
  );

  logic fetch_seen;
  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) fetch_seen <= 1'b0;
    else if (rom_req_valid && rom_req_ready) fetch_seen <= 1'b1;
  end

  assert_no_bus_in_reset_R1: assert property (@(posedge clk) disable iff (!rst_n_in)
    !rst_out_n |-> !rom_req_valid && !save_link_we && !force_we);
  assert_link_then_status_R2: assert property (@(posedge clk) disable iff (!rst_sync)
    save_link_we |=> save_stat_we && !save_link_we);
  assert_status_then_force_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    save_stat_we |=> force_we);
  assert_mode_forced_R3: assert property (@(posedge clk) disable iff (!rst_sync)
    force_we |=> core_mode == MODE_SUPV && core_irq_mask && core_fiq_mask);
  assert_strap_held_R5: assert property (@(posedge clk) disable iff (!rst_sync)
    $past(rst_sync) |-> $stable(rom_wide));
  assert_fetch_after_lock_R8: assert property (@(posedge clk) disable iff (!rst_sync)
    rom_req_valid |-> clk_ready);
  assert_first_fetch_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    rom_req_valid && !fetch_seen |-> rom_req_addr == 32'h0);
  assert_quiet_when_done_R9: assert property (@(posedge clk) disable iff (!rst_sync)
    boot_done |-> !rom_req_valid && !instr_valid);

endmodule

// File: tb/boot_reset_seq_bench.sv
`timescale 1ns/1ps
module boot_reset_seq_bench;

  localparam int L  = 5;
  localparam int BW = 4;

  logic        clk = 1'b0;
  logic        rst_n_in = 1'b0;
  logic        strap_wide = 1'b1;
  logic        rst_out_n, core_hold;
  logic [31:0] cur_pc = '0, cur_status = '0;
  logic        save_link_we, save_stat_we, force_we;
  logic [31:0] save_data;
  logic [4:0]  core_mode;
  logic        core_irq_mask, core_fiq_mask;
  logic [5:0]  sys_ctl;
  logic        clk_ready, rom_wide;
  logic        rom_req_valid, rom_req_ready = 1'b0, rom_req_size;
  logic [31:0] rom_req_addr;
  logic        rom_rsp_valid = 1'b0, rom_rsp_ready;
  logic [31:0] rom_rsp_data = '0;
  logic        instr_valid, instr_ready = 1'b0;
  logic [31:0] instr_data, instr_addr;
  logic        boot_done;

  always #2.5 clk = ~clk;

  boot_reset_seq #(.LOCK_CYCLES(L), .BOOT_WORDS(BW)) u_boot_reset_seq (
    .clk(clk), .rst_n_in(rst_n_in), .strap_wide(strap_wide),
    .rst_out_n(rst_out_n), .core_hold(core_hold),
    .cur_pc(cur_pc), .cur_status(cur_status),
    .save_link_we(save_link_we), .save_stat_we(save_stat_we), .save_data(save_data),
    .force_we(force_we), .core_mode(core_mode),
    .core_irq_mask(core_irq_mask), .core_fiq_mask(core_fiq_mask),
    .sys_ctl(sys_ctl), .clk_ready(clk_ready), .rom_wide(rom_wide),
    .rom_req_valid(rom_req_valid), .rom_req_ready(rom_req_ready),
    .rom_req_addr(rom_req_addr), .rom_req_size(rom_req_size),
    .rom_rsp_valid(rom_rsp_valid), .rom_rsp_ready(rom_rsp_ready),
    .rom_rsp_data(rom_rsp_data),
    .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_data(instr_data), .instr_addr(instr_addr), .boot_done(boot_done)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rom_half(input logic [31:0] a);
    return 16'((a * 37) ^ 32'h0000A55A);
  endfunction

  function automatic logic [31:0] exp_word(input int i);
    logic [31:0] b;
    b = 32'(i) * 4;
    return {rom_half(b + 2), rom_half(b)};
  endfunction

  bit          exp_wide = 1'b1;
  int          req_n = 0, word_n = 0, cyc = 0;
  bit          req_fire = 1'b0, rsp_fire = 1'b0, outstanding = 1'b0;
  int          wait_cnt = 0;
  logic [31:0] addr_l = '0;
  bit          prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  // ROM model and instruction consumer, with rotating stall patterns
  initial begin
    forever begin
      @(negedge clk);
      if (rsp_fire) rom_rsp_valid = 1'b0;
      if (req_fire) begin
        outstanding = 1'b1;
        wait_cnt    = cyc % 3;
        addr_l      = rom_req_addr;
      end
      if (outstanding && !rom_rsp_valid) begin
        if (wait_cnt == 0) begin
          rom_rsp_valid = 1'b1;
          rom_rsp_data  = exp_wide ? {rom_half(addr_l + 2), rom_half(addr_l)}
                                   : {16'hDEAD, rom_half(addr_l)};
          outstanding   = 1'b0;
        end else wait_cnt--;
      end
      rom_req_ready = (cyc % 4) != 1;
      instr_ready   = (cyc % 3) != 2;
      cyc++;
      #1;
      if (!rst_out_n) begin
        outstanding = 1'b0; rom_rsp_valid = 1'b0; req_fire = 1'b0; rsp_fire = 1'b0;
        req_n = 0; word_n = 0; prev_stall = 1'b0;
      end else begin
        req_fire = rom_req_valid && rom_req_ready;
        rsp_fire = rom_rsp_valid && rom_rsp_ready;
        if (rom_req_valid) begin
          logic [31:0] ea;
          ea = exp_wide ? 32'(req_n) * 4 : 32'(req_n / 2) * 4 + 32'((req_n % 2) * 2);
          chk(rom_req_addr == ea, exp_wide ? "R6 addr" : "R7 addr", rom_req_addr, ea);
          chk(rom_req_size == exp_wide, "R5 size", 32'(rom_req_size), 32'(exp_wide));
          chk(clk_ready == 1'b1, "R8 req before ready", 32'(clk_ready), 32'd1);
          chk(req_n < (exp_wide ? BW : 2 * BW), "R9 extra request", 32'(req_n), 32'(BW));
          if (req_fire) req_n++;
        end
        if (prev_stall)
          chk(instr_valid && instr_data == prev_data, "R10 word hold", instr_data, prev_data);
        if (instr_valid && instr_ready) begin
          chk(instr_data == exp_word(word_n), exp_wide ? "R6 word" : "R7 word",
              instr_data, exp_word(word_n));
          chk(instr_addr == 32'(word_n) * 4, "R9 word addr", instr_addr, 32'(word_n) * 4);
          word_n++;
        end
        prev_stall = instr_valid && !instr_ready;
        prev_data  = instr_data;
      end
    end
  end

  task automatic boot(input bit wide, input logic [31:0] pc, input logic [31:0] st,
                      input bit abort);
    @(negedge clk);
    rst_n_in = 1'b0; strap_wide = wide; exp_wide = wide; cur_pc = pc; cur_status = st;
    repeat (3) @(negedge clk);
    #1;
    chk(rst_out_n == 0 && core_hold == 1, "R1 reset out", {30'b0, rst_out_n, core_hold}, 32'd1);
    chk(!rom_req_valid && !save_link_we && !save_stat_we && !force_we, "R1 quiet",
        {28'b0, rom_req_valid, save_link_we, save_stat_we, force_we}, 32'd0);
    @(negedge clk);
    rst_n_in = 1'b1;
    for (int k = 1; k <= 6 + L; k++) begin
      @(negedge clk);
      #1;
      if (k <= 2) begin
        chk(!rst_out_n && !save_link_we, "R1 sync hold", {30'b0, rst_out_n, save_link_we}, 32'd0);
        if (k == 2) strap_wide = !wide;
      end
      if (k == 3) begin
        chk(save_link_we && !save_stat_we, "R2 link strobe", {30'b0, save_link_we, save_stat_we}, 32'd2);
        chk(save_data == pc, "R2 link data", save_data, pc);
      end
      if (k == 4) begin
        chk(save_stat_we && !save_link_we && !force_we, "R2 status strobe",
            {29'b0, save_link_we, save_stat_we, force_we}, 32'd2);
        chk(save_data == st, "R2 status data", save_data, st);
      end
      if (k == 5) chk(force_we == 1, "R3 force strobe", 32'(force_we), 32'd1);
      if (k == 6) begin
        chk({core_mode, core_irq_mask, core_fiq_mask} == {5'b10011, 2'b11}, "R3 mode",
            32'({core_mode, core_irq_mask, core_fiq_mask}), 32'({5'b10011, 2'b11}));
        chk(sys_ctl == 6'b0, "R4 sys ctl", 32'(sys_ctl), 32'd0);
      end
      if (k >= 6 && k <= 5 + L) chk(clk_ready == 0, "R8 early ready", 32'(clk_ready), 32'd0);
      if (k == 6 + L) begin
        chk(clk_ready == 1, "R8 ready", 32'(clk_ready), 32'd1);
        chk(rom_wide == wide, "R5 strap", 32'(rom_wide), 32'(wide));
      end
    end
    if (abort) begin
      for (int t = 0; t < 200 && word_n < 2; t++) @(negedge clk);
      @(negedge clk);
      #2;
      rst_n_in = 1'b0;
      #1;
      chk(!rst_out_n && !rom_req_valid && !clk_ready, "R11 async",
          {29'b0, rst_out_n, rom_req_valid, clk_ready}, 32'd0);
    end else begin
      for (int t = 0; t < 400 && !boot_done; t++) @(negedge clk);
      #1;
      chk(boot_done && !core_hold, "R9 done", {30'b0, boot_done, core_hold}, 32'd2);
      chk(word_n == BW, "R9 word count", 32'(word_n), 32'(BW));
      chk(req_n == (wide ? BW : 2 * BW), wide ? "R6 req count" : "R7 req count",
          32'(req_n), 32'(wide ? BW : 2 * BW));
      repeat (6) @(negedge clk);
      #1;
      chk(!rom_req_valid && rom_wide == wide && sys_ctl == 6'b0, "R5 R4 after done",
          {30'b0, rom_req_valid, rom_wide}, {31'b0, wide});
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    boot(1'b1, 32'h1234_5678, 32'h8000_00D3, 1'b0);
    boot(1'b0, 32'hCAFE_0004, 32'h6000_001F, 1'b0);
    boot(1'b0, 32'h0000_0010, 32'h0000_0010, 1'b1);
    boot(1'b1, 32'hFFFF_FFFC, 32'hF000_00DF, 1'b1);
    boot(1'b1, 32'h0BAD_F00D, 32'h2000_0013, 1'b0);
    boot(1'b0, 32'h5555_AAAA, 32'hAAAA_5555, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule